// File: doc/BRIEF.md
# Masked Bank Address Translator

This block sits between the host's bank registers and the memory decoders. For each access it takes the bank index selected by the host and an area code (first ROM window, second ROM window, extended ROM window, RAM window) and produces the physical bank number that reaches the memories. A 16-bit mask register limits the bank index to the memory actually fitted. The register holds a 9-bit ROM mask, a 4-bit RAM mask and one apply bit for each of the ROM0, ROM1 and RAM areas.

In the RAM window the translated bank is steered either to the SRAM or to an alternate RAM target. A mirroring control holds SRAM address line 15 low, so a 64 KB page behaves as 32 KB. Combined with the RAM mask, this makes the cartridge look as if it carries a 32 KB SRAM. The mask register is written one byte lane at a time. Translation is combinational, so each access sees the mask that is in force in that cycle.

Top module: `bank_xlate`

## Requirements
- R1: While reset is asserted and right after it, all sixteen mask register bits read 1 (0xFFFF), so every bank index passes through unchanged.
- R2: A write with lane select 0 loads mask bits 7:0 from the data byte, and lane select 1 loads bits 15:8. The new value applies from the cycle after the write edge, and the other lane keeps its value.
- R3: In the ROM0 area (area code 0), the output bank is the bank index ANDed with mask bits 8:0 when mask bit 9 is 1, and the bank index unchanged when bit 9 is 0.
- R4: In the ROM1 area (area code 1), the same rule applies, controlled by mask bit 10.
- R5: In the extended ROM area (area code 2), the bank index is always ANDed with mask bits 8:0, whatever bits 9 to 11 hold.
- R6: In the RAM area (area code 3), output bits 3:0 are bank index bits 3:0 ANDed with mask bits 15:12 when mask bit 11 is 1, and unchanged when bit 11 is 0. Output bits 8:4 are 0.
- R7: The SRAM select is 1 only in the RAM area, with SRAM enabled, and with a translated RAM bank from 0 to 7. The alternate RAM select is 1 for every other RAM-area access. Both selects are 0 in the ROM areas.
- R8: With mirroring on, the SRAM address line 15 output is 0. With mirroring off, it follows the host address bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Mask register byte write strobe |
| wr_lane_i | input | 1 | Byte lane: 0 = bits 7:0, 1 = bits 15:8 |
| wr_data_i | input | 8 | Byte to write |
| area_i | input | 2 | 0 = ROM0, 1 = ROM1, 2 = extended ROM, 3 = RAM |
| bank_i | input | 9 | Host bank index |
| addr15_i | input | 1 | Host address bit 15 for the RAM window |
| sram_en_i | input | 1 | SRAM enable |
| mirror_en_i | input | 1 | 32 KB mirroring enable |
| mask_o | output | 16 | Current mask register contents |
| phys_bank_o | output | 9 | Translated bank |
| sram_sel_o | output | 1 | RAM access goes to SRAM |
| alt_sel_o | output | 1 | RAM access goes to the alternate RAM target |
| sram_a15_o | output | 1 | SRAM address line 15 |

## Verification
A mask byte write and a translation can happen in the same cycle, and the translation must then use the old mask. The bench provokes this by presenting an extended-ROM access together with a lane 0 write of 0x00. It checks the output before the clock edge against the old mask and after the edge against the new one. The rest of the run sweeps every area, all 512 bank indices and all combinations of SRAM enable, mirroring and address bit 15, under seven mask values that are loaded through the byte lanes. All expected values are computed arithmetically.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  typedef enum logic [1:0] {
    AREA_ROM0 = 2'd0,
    AREA_ROM1 = 2'd1,
    AREA_ROMX = 2'd2,
    AREA_RAM  = 2'd3
  } area_e;

  // apply-bit offsets above the ROM mask field
  localparam int unsigned APPLY_ROM0 = 0;
  localparam int unsigned APPLY_ROM1 = 1;
  localparam int unsigned APPLY_RAM  = 2;
  localparam int unsigned APPLY_BITS = 3;
endpackage

// File: rtl/bank_mask_reg.sv
module bank_mask_reg #(
  parameter int unsigned MASK_W     = 16,
  parameter int unsigned LANES      = MASK_W / 8,
  parameter int unsigned LANE_SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [LANE_SEL_W-1:0] wr_lane_i,
  input  logic [7:0]            wr_data_i,
  output logic [MASK_W-1:0]     mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '1;
      else if (wr_en_i && wr_lane_i == LANE_SEL_W'(l)) q <= wr_data_i;
    end
    assign mask_o[l*8 +: 8] = q;
  end
endmodule

// File: rtl/bank_mask_apply.sv
module bank_mask_apply
  import bank_xlate_pkg::*;
#(
  parameter int unsigned ROM_W  = 9,
  parameter int unsigned RAM_W  = 4,
  parameter int unsigned MASK_W = ROM_W + APPLY_BITS + RAM_W
) (
  input  area_e             area_i,
  input  logic [ROM_W-1:0]  bank_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ROM_W-1:0]  phys_bank_o,
  output logic [RAM_W-1:0]  ram_bank_o
);
  logic [ROM_W-1:0] rom_mask;
  logic [RAM_W-1:0] ram_mask;
  logic             apply;
  logic [ROM_W-1:0] rom_eff;

  assign rom_mask = mask_i[ROM_W-1:0];
  assign ram_mask = mask_i[MASK_W-1 -: RAM_W];

  always_comb begin
    unique case (area_i)
      AREA_ROM0: apply = mask_i[ROM_W + APPLY_ROM0];
      AREA_ROM1: apply = mask_i[ROM_W + APPLY_ROM1];
      AREA_ROMX: apply = 1'b1; // extended window ignores apply bits
      default:   apply = mask_i[ROM_W + APPLY_RAM];
    endcase
  end

  assign rom_eff    = apply ? (bank_i & rom_mask) : bank_i;
  assign ram_bank_o = apply ? (bank_i[RAM_W-1:0] & ram_mask) : bank_i[RAM_W-1:0];
  assign phys_bank_o = (area_i == AREA_RAM) ? {{(ROM_W-RAM_W){1'b0}}, ram_bank_o} : rom_eff;
endmodule

// File: rtl/bank_target_sel.sv
module bank_target_sel
  import bank_xlate_pkg::*;
#(
  parameter int unsigned RAM_W      = 4,
  parameter int unsigned SRAM_BANKS = 8
) (
  input  area_e            area_i,
  input  logic [RAM_W-1:0] ram_bank_i,
  input  logic             sram_en_i,
  input  logic             mirror_en_i,
  input  logic             addr15_i,
  output logic             sram_sel_o,
  output logic             alt_sel_o,
  output logic             sram_a15_o
);
  logic is_ram, in_sram;

  assign is_ram     = (area_i == AREA_RAM);
  assign in_sram    = {1'b0, ram_bank_i} < (RAM_W+1)'(SRAM_BANKS);
  assign sram_sel_o = is_ram && sram_en_i && in_sram;
  assign alt_sel_o  = is_ram && !sram_sel_o;
  assign sram_a15_o = addr15_i && !mirror_en_i;
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int unsigned ROM_W      = 9,
  parameter int unsigned RAM_W      = 4,
  parameter int unsigned SRAM_BANKS = 8,
  localparam int unsigned MASK_W     = ROM_W + APPLY_BITS + RAM_W,
  localparam int unsigned LANES      = MASK_W / 8,
  localparam int unsigned LANE_SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [LANE_SEL_W-1:0] wr_lane_i,
  input  logic [7:0]            wr_data_i,
  input  logic [1:0]            area_i,
  input  logic [ROM_W-1:0]      bank_i,
  input  logic                  addr15_i,
  input  logic                  sram_en_i,
  input  logic                  mirror_en_i,
  output logic [MASK_W-1:0]     mask_o,
  output logic [ROM_W-1:0]      phys_bank_o,
  output logic                  sram_sel_o,
  output logic                  alt_sel_o,
  output logic                  sram_a15_o
);
  area_e            area;
  logic [RAM_W-1:0] ram_bank;

  assign area = area_e'(area_i);

  bank_mask_reg #(.MASK_W(MASK_W), .LANES(LANES), .LANE_SEL_W(LANE_SEL_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_lane_i, .wr_data_i, .mask_o
  );

  bank_mask_apply #(.ROM_W(ROM_W), .RAM_W(RAM_W), .MASK_W(MASK_W)) u_apply (
    .area_i(area), .bank_i, .mask_i(mask_o), .phys_bank_o, .ram_bank_o(ram_bank)
  );

  bank_target_sel #(.RAM_W(RAM_W), .SRAM_BANKS(SRAM_BANKS)) u_sel (
    .area_i(area), .ram_bank_i(ram_bank), .sram_en_i, .mirror_en_i, .addr15_i,
    .sram_sel_o, .alt_sel_o, .sram_a15_o
  );
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int unsigned ROM_W      = 9,
  parameter int unsigned RAM_W      = 4,
  parameter int unsigned MASK_W     = 16,
  parameter int unsigned LANE_SEL_W = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [LANE_SEL_W-1:0] wr_lane_i,
  input logic [7:0]            wr_data_i,
  input logic [1:0]            area_i,
  input logic [ROM_W-1:0]      bank_i,
  input logic                  mirror_en_i,
  input logic [MASK_W-1:0]     mask_o,
  input logic [ROM_W-1:0]      phys_bank_o,
  input logic                  sram_sel_o,
  input logic                  alt_sel_o,
  input logic                  sram_a15_o
);
  assert_lane_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_lane_i == '0) |=> (mask_o[7:0] == $past(wr_data_i)) &&
                                     (mask_o[MASK_W-1:8] == $past(mask_o[MASK_W-1:8])));

  assert_lane_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_lane_i == LANE_SEL_W'(1)) |=> (mask_o[15:8] == $past(wr_data_i)) &&
                                                (mask_o[7:0] == $past(mask_o[7:0])));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_o));

  assert_ext_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_i == 2'd2) |-> ((phys_bank_o & ~mask_o[ROM_W-1:0]) == '0));

  assert_rom_no_bits_added_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_i != 2'd3) |-> ((phys_bank_o & ~bank_i) == '0));

  assert_ram_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_i == 2'd3) |-> (phys_bank_o[ROM_W-1:RAM_W] == '0));

  assert_sel_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sram_sel_o, alt_sel_o}));

  assert_rom_no_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_i != 2'd3) |-> !(sram_sel_o || alt_sel_o));

  assert_mirror_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_en_i |-> !sram_a15_o);
endmodule

bind bank_xlate bank_xlate_chk #(
  .ROM_W(ROM_W), .RAM_W(RAM_W), .MASK_W(MASK_W), .LANE_SEL_W(LANE_SEL_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_lane_i(wr_lane_i),
  .wr_data_i(wr_data_i), .area_i(area_i), .bank_i(bank_i), .mirror_en_i(mirror_en_i),
  .mask_o(mask_o), .phys_bank_o(phys_bank_o), .sram_sel_o(sram_sel_o),
  .alt_sel_o(alt_sel_o), .sram_a15_o(sram_a15_o)
);

// File: tb/bank_xlate_tb_top.sv
module bank_xlate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_lane_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [1:0]  area_i = '0;
  logic [8:0]  bank_i = '0;
  logic        addr15_i = 1'b0;
  logic        sram_en_i = 1'b0;
  logic        mirror_en_i = 1'b0;
  logic [15:0] mask_o;
  logic [8:0]  phys_bank_o;
  logic        sram_sel_o, alt_sel_o, sram_a15_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bank_xlate dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_lane_i, .wr_data_i, .area_i, .bank_i,
    .addr15_i, .sram_en_i, .mirror_en_i, .mask_o, .phys_bank_o,
    .sram_sel_o, .alt_sel_o, .sram_a15_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (area %0d bank 0x%0h mask 0x%0h)",
               req, act, exp, area_i, bank_i, mask_o);
    end
  endtask

  task automatic wr_byte(logic lane, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_lane_i = lane; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [8:0] exp_bank(logic [15:0] m, int a, logic [8:0] b);
    logic [3:0] rb;
    case (a)
      0: return m[9]  ? (b & m[8:0]) : b;
      1: return m[10] ? (b & m[8:0]) : b;
      2: return b & m[8:0];
      default: begin
        rb = m[11] ? (b[3:0] & m[15:12]) : b[3:0];
        return {5'b0, rb};
      end
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] masks [7];
    masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'h5A3C; masks[3] = 16'h81FF;
    masks[4] = 16'h0E55; masks[5] = 16'hF1AA; masks[6] = 16'h7600;

    #2 rst_ni = 1'b0;
    #1 chk("R1", mask_o, 16'hFFFF);
    area_i = 2'd2; bank_i = 9'h1FF; #1;
    chk("R1", {7'b0, phys_bank_o}, 16'h01FF);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i) chk("R1", mask_o, 16'hFFFF);

    // lane 1 alone, then lane 0 alone
    wr_byte(1'b1, 8'h3C);
    chk("R2", mask_o, 16'h3CFF);
    wr_byte(1'b0, 8'h81);
    chk("R2", mask_o, 16'h3C81);

    // write and translate in the same cycle: old mask until the edge
    wr_byte(1'b0, 8'hFF);
    wr_byte(1'b1, 8'hFF);
    @(negedge clk_i);
    area_i = 2'd2; bank_i = 9'h1FF;
    wr_en_i = 1'b1; wr_lane_i = 1'b0; wr_data_i = 8'h00;
    #1 chk("R2", {7'b0, phys_bank_o}, 16'h01FF);
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    chk("R2", {7'b0, phys_bank_o}, 16'h0100);
    chk("R5", {7'b0, phys_bank_o}, 16'h0100);

    for (int mi = 0; mi < 7; mi++) begin
      wr_byte(1'b0, masks[mi][7:0]);
      wr_byte(1'b1, masks[mi][15:8]);
      chk("R2", mask_o, masks[mi]);
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 512; b++) begin
          for (int s = 0; s < 8; s++) begin
            logic [8:0] eb;
            logic es, ea, e15;
            area_i = 2'(a); bank_i = 9'(b);
            sram_en_i = s[0]; mirror_en_i = s[1]; addr15_i = s[2];
            #1;
            eb  = exp_bank(masks[mi], a, 9'(b));
            es  = (a == 3) && s[0] && (eb < 9'd8);
            ea  = (a == 3) && !es;
            e15 = s[2] && !s[1];
            case (a)
              0: chk("R3", {7'b0, phys_bank_o}, {7'b0, eb});
              1: chk("R4", {7'b0, phys_bank_o}, {7'b0, eb});
              2: chk("R5", {7'b0, phys_bank_o}, {7'b0, eb});
              default: chk("R6", {7'b0, phys_bank_o}, {7'b0, eb});
            endcase
            chk("R7", {14'b0, sram_sel_o, alt_sel_o}, {14'b0, es, ea});
            chk("R8", {15'b0, sram_a15_o}, {15'b0, e15});
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule